// File: doc/BRIEF.md
# Debug Register Access Gate

This block decides the fate of a coprocessor-style move to or from one debug control register. Each access carries its encoding fields, a direction, the privilege level it was issued from, and a snapshot of the system controls. These controls cover which features are implemented, whether levels 2 and 3 run 64-bit or 32-bit, the level-2 enable, the trap-control bits of levels 2 and 3, and two secure-debug conditions. The block returns exactly one verdict: allow, undefined, trap to level 2, or trap to level 3. With the verdict it returns a 6-bit syndrome class, and a flag that marks a level-2 trap taken through the 32-bit hypervisor path.

Each privilege level has its own fixed priority chain. At level 1, a level-3 check that forces undefined ranks first. The level-2 trap checks come next, and the remaining level-3 trap check comes last. At level 2, only the two level-3 checks apply. At level 3, the access always passes.

The verdict is registered. It appears one cycle after a request strobe, together with a valid flag and the echoed direction, so that a later stage can raise the exception or update the register file.

Top module: `dbg_acc_gate`

## Requirements
- R1: An access is recognised only when coprocessor = 4'b1110, opc1 = 3'b000, CRn = 4'b0000, CRm = 4'b0111 and opc2 = 3'b000. Any other encoding gives undefined with class 0.
- R2: When the 32-bit level-1 feature flag is low, the verdict is undefined. An access from level 0 (cur_lvl = 2'd0) is also undefined.
- R3: At level 1 (cur_lvl = 2'd1), the access is undefined when level 3 is present, runs 64-bit, has its debug-trap bit set, and the undefined-priority condition holds. This check wins over every other check.
- R4: At level 1, when R3 does not fire and level 2 is enabled with either of its two trap bits set, the verdict is trap to level 2 with class 6'h05. rsp_l2_hyp is 1 exactly when level 2 runs 32-bit.
- R5: After R3 and R4, a level-3 trap applies when level 3 is present and 64-bit with its debug-trap bit set. The verdict is undefined if the secure-debug-undefined input is 1, and otherwise trap to level 3 with class 6'h05. The level-3 checks are skipped when level 3 is absent or runs 32-bit.
- R6: At level 2 (cur_lvl = 2'd2), only the R3 and R5 level-3 checks apply, in that order. The level-2 trap bits have no effect.
- R7: At level 3 (cur_lvl = 2'd3), a recognised access with the feature present is always allowed, whatever the trap controls are.
- R8: When no rule fires, the verdict is allow. Allow and undefined verdicts carry class 0.
- R9: The verdict, class and hyp flag appear in the cycle after req_valid, and rsp_valid is high in that cycle only. Exactly one verdict output is high while rsp_valid is high. All results hold their values while no request arrives.
- R10: Reads and writes give identical verdicts. rsp_is_write returns the request direction alongside the verdict.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_is_write | input | 1 | 1 = write to the register, 0 = read |
| enc_cp | input | 4 | Coprocessor number field |
| enc_op1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_op2 | input | 3 | Second opcode field |
| cur_lvl | input | 2 | Privilege level of the access (0 to 3) |
| feat_a32_l1 | input | 1 | 32-bit level-1 support implemented |
| l3_present | input | 1 | Level 3 implemented |
| l3_is_a64 | input | 1 | Level 3 runs 64-bit |
| l3_trap_dbg | input | 1 | Level-3 debug-access trap bit |
| sdd_undef_prio | input | 1 | Secure-debug undefined takes priority |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| l2_enabled | input | 1 | Level 2 enabled for the current state |
| l2_is_a64 | input | 1 | Level 2 runs 64-bit |
| l2_trap | input | 2 | Level-2 trap-control bits (either one traps) |
| rsp_valid | output | 1 | Verdict valid this cycle |
| rsp_allow | output | 1 | Access is permitted |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap_l2 | output | 1 | Access traps to level 2 |
| rsp_trap_l3 | output | 1 | Access traps to level 3 |
| rsp_l2_hyp | output | 1 | Level-2 trap uses the 32-bit hypervisor path |
| rsp_class | output | 6 | Syndrome class of the trap |
| rsp_is_write | output | 1 | Echoed access direction |

## Verification
The hardest case to reach from the ports is a level-1 access where the rules overlap. In that case the undefined-priority condition, the level-2 trap bits and the level-3 trap bit are all true together, so only the order of the chain decides the verdict. Directed items build these overlaps one layer at a time: all three conditions, then the top one removed, then the middle one removed. The same control snapshots are replayed at level 2 and level 3, where the level-2 bits must be ignored. A run of pseudo-random snapshots over every field then covers combinations the directed list misses.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

  localparam int unsigned LVL_W        = 2;
  localparam int unsigned NUM_VERDICTS = 4;

  typedef enum logic [1:0] {
    VD_ALLOW   = 2'd0,
    VD_UNDEF   = 2'd1,
    VD_TRAP_L2 = 2'd2,
    VD_TRAP_L3 = 2'd3
  } verdict_e;

  typedef struct packed {
    logic       feat_a32_l1;
    logic       l3_present;
    logic       l3_is_a64;
    logic       l3_trap_dbg;
    logic       sdd_undef_prio;
    logic       sdd_undef;
    logic       l2_enabled;
    logic       l2_is_a64;
    logic [1:0] l2_trap;
  } ctl_t;

endpackage

// File: rtl/dbg_acc_match.sv
module dbg_acc_match #(
  parameter int unsigned CP_W   = 4,
  parameter int unsigned OP1_W  = 3,
  parameter int unsigned CRN_W  = 4,
  parameter int unsigned CRM_W  = 4,
  parameter int unsigned OP2_W  = 3,
  parameter logic [CP_W-1:0]  CP_VAL  = 4'b1110,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'b000,
  parameter logic [CRN_W-1:0] CRN_VAL = 4'b0000,
  parameter logic [CRM_W-1:0] CRM_VAL = 4'b0111,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'b000
) (
  input  logic [CP_W-1:0]  enc_cp,
  input  logic [OP1_W-1:0] enc_op1,
  input  logic [CRN_W-1:0] enc_crn,
  input  logic [CRM_W-1:0] enc_crm,
  input  logic [OP2_W-1:0] enc_op2,
  output logic             hit
);

  localparam int unsigned ENC_W = CP_W + OP1_W + CRN_W + CRM_W + OP2_W;
  localparam logic [ENC_W-1:0] ENC_VAL = {CP_VAL, OP1_VAL, CRN_VAL, CRM_VAL, OP2_VAL};

  logic [ENC_W-1:0] enc_all;

  always_comb begin
    enc_all = {enc_cp, enc_op1, enc_crn, enc_crm, enc_op2};
    hit     = (enc_all == ENC_VAL);
  end

endmodule

// File: rtl/dbg_acc_rules.sv
module dbg_acc_rules
  import dbg_acc_pkg::*;
#(
  parameter int unsigned       CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h05
) (
  input  logic                hit,
  input  logic [LVL_W-1:0]    lvl,
  input  ctl_t                ctl,
  output verdict_e            verdict,
  output logic                l2_hyp,
  output logic [CLASS_W-1:0]  cls
);

  logic l3_arm;
  logic l3_force_undef;
  logic l2_arm;

  always_comb begin
    // Level-3 checks are active only for a present, 64-bit level 3.
    l3_arm         = ctl.l3_present && ctl.l3_is_a64 && ctl.l3_trap_dbg;
    l3_force_undef = l3_arm && ctl.sdd_undef_prio;
    l2_arm         = ctl.l2_enabled && (|ctl.l2_trap);
    verdict        = VD_UNDEF;
    l2_hyp         = 1'b0;

    if (hit && ctl.feat_a32_l1) begin
      unique case (lvl)
        2'd0: verdict = VD_UNDEF;
        2'd1: begin
          if (l3_force_undef) begin
            verdict = VD_UNDEF;
          end else if (l2_arm) begin
            verdict = VD_TRAP_L2;
            l2_hyp  = !ctl.l2_is_a64;
          end else if (l3_arm) begin
            verdict = ctl.sdd_undef ? VD_UNDEF : VD_TRAP_L3;
          end else begin
            verdict = VD_ALLOW;
          end
        end
        2'd2: begin
          if (l3_force_undef) begin
            verdict = VD_UNDEF;
          end else if (l3_arm) begin
            verdict = ctl.sdd_undef ? VD_UNDEF : VD_TRAP_L3;
          end else begin
            verdict = VD_ALLOW;
          end
        end
        default: verdict = VD_ALLOW;
      endcase
    end

    cls = ((verdict == VD_TRAP_L2) || (verdict == VD_TRAP_L3)) ? TRAP_CLASS : '0;
  end

endmodule

// File: rtl/dbg_acc_resreg.sv
module dbg_acc_resreg
  import dbg_acc_pkg::*;
#(
  parameter int unsigned CLASS_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  verdict_e                verdict_in,
  input  logic                    hyp_in,
  input  logic [CLASS_W-1:0]      cls_in,
  input  logic                    wr_in,
  output logic                    vld_out,
  output logic [NUM_VERDICTS-1:0] onehot_out,
  output logic                    hyp_out,
  output logic [CLASS_W-1:0]      cls_out,
  output logic                    wr_out
);

  logic               vld_q, vld_d;
  logic               have_q, have_d;
  verdict_e           verd_q, verd_d;
  logic               hyp_q, hyp_d;
  logic [CLASS_W-1:0] cls_q, cls_d;
  logic               wr_q, wr_d;

  always_comb begin
    vld_d  = load;
    have_d = have_q;
    verd_d = verd_q;
    hyp_d  = hyp_q;
    cls_d  = cls_q;
    wr_d   = wr_q;
    if (load) begin
      have_d = 1'b1;
      verd_d = verdict_in;
      hyp_d  = hyp_in;
      cls_d  = cls_in;
      wr_d   = wr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      have_q <= 1'b0;
      verd_q <= VD_ALLOW;
      hyp_q  <= 1'b0;
      cls_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      have_q <= have_d;
      verd_q <= verd_d;
      hyp_q  <= hyp_d;
      cls_q  <= cls_d;
      wr_q   <= wr_d;
    end
  end

  for (genvar gi = 0; gi < NUM_VERDICTS; gi++) begin : g_onehot
    assign onehot_out[gi] = have_q && (verd_q == verdict_e'(gi));
  end

  assign vld_out = vld_q;
  assign hyp_out = hyp_q;
  assign cls_out = cls_q;
  assign wr_out  = wr_q;

endmodule

// File: rtl/dbg_acc_gate.sv
module dbg_acc_gate
  import dbg_acc_pkg::*;
#(
  parameter int unsigned CLASS_W = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_is_write,
  input  logic [3:0]         enc_cp,
  input  logic [2:0]         enc_op1,
  input  logic [3:0]         enc_crn,
  input  logic [3:0]         enc_crm,
  input  logic [2:0]         enc_op2,
  input  logic [1:0]         cur_lvl,
  input  logic               feat_a32_l1,
  input  logic               l3_present,
  input  logic               l3_is_a64,
  input  logic               l3_trap_dbg,
  input  logic               sdd_undef_prio,
  input  logic               sdd_undef,
  input  logic               l2_enabled,
  input  logic               l2_is_a64,
  input  logic [1:0]         l2_trap,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic               rsp_undef,
  output logic               rsp_trap_l2,
  output logic               rsp_trap_l3,
  output logic               rsp_l2_hyp,
  output logic [CLASS_W-1:0] rsp_class,
  output logic               rsp_is_write
);

  logic                    enc_hit;
  ctl_t                    ctl;
  verdict_e                verdict;
  logic                    hyp;
  logic [CLASS_W-1:0]      cls;
  logic [NUM_VERDICTS-1:0] onehot;

  always_comb begin
    ctl.feat_a32_l1    = feat_a32_l1;
    ctl.l3_present     = l3_present;
    ctl.l3_is_a64      = l3_is_a64;
    ctl.l3_trap_dbg    = l3_trap_dbg;
    ctl.sdd_undef_prio = sdd_undef_prio;
    ctl.sdd_undef      = sdd_undef;
    ctl.l2_enabled     = l2_enabled;
    ctl.l2_is_a64      = l2_is_a64;
    ctl.l2_trap        = l2_trap;
  end

  dbg_acc_match u_match (
    .enc_cp  (enc_cp),
    .enc_op1 (enc_op1),
    .enc_crn (enc_crn),
    .enc_crm (enc_crm),
    .enc_op2 (enc_op2),
    .hit     (enc_hit)
  );

  dbg_acc_rules #(
    .CLASS_W    (CLASS_W),
    .TRAP_CLASS (TRAP_CLASS)
  ) u_rules (
    .hit     (enc_hit),
    .lvl     (cur_lvl),
    .ctl     (ctl),
    .verdict (verdict),
    .l2_hyp  (hyp),
    .cls     (cls)
  );

  dbg_acc_resreg #(
    .CLASS_W (CLASS_W)
  ) u_resreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (req_valid),
    .verdict_in (verdict),
    .hyp_in     (hyp),
    .cls_in     (cls),
    .wr_in      (req_is_write),
    .vld_out    (rsp_valid),
    .onehot_out (onehot),
    .hyp_out    (rsp_l2_hyp),
    .cls_out    (rsp_class),
    .wr_out     (rsp_is_write)
  );

  assign rsp_allow   = onehot[VD_ALLOW];
  assign rsp_undef   = onehot[VD_UNDEF];
  assign rsp_trap_l2 = onehot[VD_TRAP_L2];
  assign rsp_trap_l3 = onehot[VD_TRAP_L3];

endmodule

// File: rtl/dbg_acc_gate_chk.sv
module dbg_acc_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_is_write,
  input logic [3:0] enc_cp,
  input logic [2:0] enc_op1,
  input logic [3:0] enc_crn,
  input logic [3:0] enc_crm,
  input logic [2:0] enc_op2,
  input logic [1:0] cur_lvl,
  input logic       feat_a32_l1,
  input logic       rsp_valid,
  input logic       rsp_allow,
  input logic       rsp_undef,
  input logic       rsp_trap_l2,
  input logic       rsp_trap_l3,
  input logic       rsp_l2_hyp,
  input logic [5:0] rsp_class,
  input logic       rsp_is_write
);

  logic enc_ok;
  assign enc_ok = (enc_cp == 4'b1110) && (enc_op1 == 3'b000) && (enc_crn == 4'b0000) &&
                  (enc_crm == 4'b0111) && (enc_op2 == 3'b000);

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_single_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_allow, rsp_undef, rsp_trap_l2, rsp_trap_l3}) == 1));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable({rsp_allow, rsp_undef, rsp_trap_l2, rsp_trap_l3, rsp_l2_hyp, rsp_class}));

  assert_bad_encoding_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !enc_ok) |=> rsp_undef);

  assert_level0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (cur_lvl == 2'd0)) |=> rsp_undef);

  assert_no_feature_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !feat_a32_l1) |=> rsp_undef);

  assert_level3_allow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_ok && feat_a32_l1 && (cur_lvl == 2'd3)) |=> rsp_allow);

  assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_trap_l2 || rsp_trap_l3)) |-> (rsp_class == 6'h05));

  assert_plain_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_allow || rsp_undef)) |-> (rsp_class == 6'h00));

  assert_hyp_implies_l2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_l2_hyp) |-> rsp_trap_l2);

  assert_direction_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_is_write == $past(req_is_write)));

endmodule

bind dbg_acc_gate dbg_acc_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_write (req_is_write),
  .enc_cp       (enc_cp),
  .enc_op1      (enc_op1),
  .enc_crn      (enc_crn),
  .enc_crm      (enc_crm),
  .enc_op2      (enc_op2),
  .cur_lvl      (cur_lvl),
  .feat_a32_l1  (feat_a32_l1),
  .rsp_valid    (rsp_valid),
  .rsp_allow    (rsp_allow),
  .rsp_undef    (rsp_undef),
  .rsp_trap_l2  (rsp_trap_l2),
  .rsp_trap_l3  (rsp_trap_l3),
  .rsp_l2_hyp   (rsp_l2_hyp),
  .rsp_class    (rsp_class),
  .rsp_is_write (rsp_is_write)
);

// File: tb/dbg_acc_gate_tb.sv
module dbg_acc_gate_tb;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_is_write;
  logic [3:0] enc_cp;
  logic [2:0] enc_op1;
  logic [3:0] enc_crn;
  logic [3:0] enc_crm;
  logic [2:0] enc_op2;
  logic [1:0] cur_lvl;
  logic       feat_a32_l1, l3_present, l3_is_a64, l3_trap_dbg;
  logic       sdd_undef_prio, sdd_undef, l2_enabled, l2_is_a64;
  logic [1:0] l2_trap;
  logic       rsp_valid, rsp_allow, rsp_undef, rsp_trap_l2, rsp_trap_l3, rsp_l2_hyp;
  logic [5:0] rsp_class;
  logic       rsp_is_write;

  int n_checks;
  int n_fails;

  typedef struct {
    logic [3:0] oh;   // {trap_l3, trap_l2, undef, allow}
    logic       hyp;
    logic [5:0] cls;
    logic       wr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  logic have_last;

  dbg_acc_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_write(req_is_write),
    .enc_cp(enc_cp), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm), .enc_op2(enc_op2),
    .cur_lvl(cur_lvl), .feat_a32_l1(feat_a32_l1), .l3_present(l3_present), .l3_is_a64(l3_is_a64),
    .l3_trap_dbg(l3_trap_dbg), .sdd_undef_prio(sdd_undef_prio), .sdd_undef(sdd_undef),
    .l2_enabled(l2_enabled), .l2_is_a64(l2_is_a64), .l2_trap(l2_trap),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_undef(rsp_undef),
    .rsp_trap_l2(rsp_trap_l2), .rsp_trap_l3(rsp_trap_l3), .rsp_l2_hyp(rsp_l2_hyp),
    .rsp_class(rsp_class), .rsp_is_write(rsp_is_write)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pack_out();
    return {rsp_trap_l3, rsp_trap_l2, rsp_undef, rsp_allow, rsp_l2_hyp, rsp_class, rsp_is_write};
  endfunction

  // Expected verdict from the requirements.
  function automatic exp_t model(string tag);
    exp_t e;
    logic ok, l3a, l2a;
    int   v;  // 0 allow, 1 undef, 2 trap l2, 3 trap l3
    e.hyp = 1'b0;
    ok  = (enc_cp == 4'b1110) && (enc_op1 == 3'd0) && (enc_crn == 4'd0) &&
          (enc_crm == 4'b0111) && (enc_op2 == 3'd0);                       // R1
    l3a = l3_present && l3_is_a64 && l3_trap_dbg;                          // R5
    l2a = l2_enabled && (l2_trap != 2'b00);                                // R4
    if (!ok || !feat_a32_l1 || cur_lvl == 2'd0) v = 1;                     // R1, R2
    else if (cur_lvl == 2'd3) v = 0;                                       // R7
    else if (l3a && sdd_undef_prio) v = 1;                                 // R3
    else if (cur_lvl == 2'd1 && l2a) begin v = 2; e.hyp = !l2_is_a64; end  // R4, R6
    else if (l3a) v = sdd_undef ? 1 : 3;                                   // R5
    else v = 0;                                                            // R8
    e.oh  = 4'b0001 << v;
    e.cls = (v >= 2) ? 6'h05 : 6'h00;
    e.wr  = req_is_write;                                                  // R10
    e.tag = tag;
    return e;
  endfunction

  task automatic set_ctl(logic [1:0] lvl, logic feat, logic l3p, logic l3w, logic l3t,
                         logic prio, logic sdd, logic l2e, logic l2w, logic [1:0] l2t);
    cur_lvl = lvl; feat_a32_l1 = feat; l3_present = l3p; l3_is_a64 = l3w; l3_trap_dbg = l3t;
    sdd_undef_prio = prio; sdd_undef = sdd; l2_enabled = l2e; l2_is_a64 = l2w; l2_trap = l2t;
  endtask

  task automatic good_enc();
    enc_cp = 4'b1110; enc_op1 = 3'd0; enc_crn = 4'd0; enc_crm = 4'b0111; enc_op2 = 3'd0;
  endtask

  // Driver: presents one request for one cycle and queues its expectation.
  task automatic send(string tag);
    @(negedge clk);
    req_valid = 1'b1;
    exp_q.push_back(model(tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each result against the queue; checks hold when idle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL R9: actual unexpected response expected none");
        end else begin
          last_exp = exp_q.pop_front();
          have_last = 1'b1;
          check(last_exp.tag, pack_out(), {last_exp.oh, last_exp.hyp, last_exp.cls, last_exp.wr});
        end
      end else if (have_last) begin
        check("R9 hold", pack_out() & 12'hFFE, {last_exp.oh, last_exp.hyp, last_exp.cls, 1'b0});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0; n_fails = 0; have_last = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_is_write = 1'b0;
    good_enc();
    set_ctl(2'd1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    repeat (3) @(negedge clk);
    check("R11 reset", {pack_out(), 3'b000} >> 3 | {11'd0, rsp_valid}, 12'h000);
    @(negedge clk); rst_n = 1'b1;

    // R1 encoding
    set_ctl(2'd3, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    send("R1 match allow");
    enc_cp = 4'b1111; send("R1 wrong cp");
    good_enc(); enc_crm = 4'b0110; send("R1 wrong crm");
    good_enc(); enc_op2 = 3'd1; send("R1 wrong op2");
    good_enc();
    // R2
    set_ctl(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00); send("R2 no feature");
    set_ctl(2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00); send("R2 level0");
    // R3 priority over everything
    set_ctl(2'd1, 1, 1, 1, 1, 1, 0, 1, 1, 2'b11); send("R3 prio beats l2");
    // R4
    set_ctl(2'd1, 1, 1, 1, 1, 0, 1, 1, 1, 2'b01); send("R4 a64 l2 trap over l3");
    set_ctl(2'd1, 1, 0, 0, 0, 0, 0, 1, 0, 2'b10); send("R4 a32 hyp trap");
    set_ctl(2'd1, 1, 0, 0, 0, 0, 0, 0, 1, 2'b11); send("R4 l2 disabled allow");
    // R5
    set_ctl(2'd1, 1, 1, 1, 1, 0, 1, 0, 1, 2'b00); send("R5 sdd undef");
    set_ctl(2'd1, 1, 1, 1, 1, 0, 0, 0, 1, 2'b00); send("R5 trap l3");
    set_ctl(2'd1, 1, 1, 0, 1, 1, 0, 0, 1, 2'b00); send("R5 l3 a32 skipped");
    set_ctl(2'd1, 1, 0, 1, 1, 1, 1, 0, 1, 2'b00); send("R5 l3 absent skipped");
    // R6
    set_ctl(2'd2, 1, 0, 0, 0, 0, 0, 1, 1, 2'b11); send("R6 l2 bits ignored");
    set_ctl(2'd2, 1, 1, 1, 1, 0, 0, 1, 0, 2'b11); send("R6 trap l3");
    set_ctl(2'd2, 1, 1, 1, 1, 1, 0, 1, 1, 2'b11); send("R6 prio undef");
    // R7
    set_ctl(2'd3, 1, 1, 1, 1, 1, 1, 1, 0, 2'b11); send("R7 always allow");
    // R8
    set_ctl(2'd1, 1, 1, 1, 0, 1, 1, 0, 1, 2'b00); send("R8 no rule allow");
    // R10 direction
    set_ctl(2'd1, 1, 0, 0, 0, 0, 0, 1, 0, 2'b01);
    req_is_write = 1'b1; send("R10 write");
    req_is_write = 1'b0; send("R10 read");
    // R9 back-to-back, then idle hold
    @(negedge clk);
    req_valid = 1'b1; set_ctl(2'd1, 1, 1, 1, 1, 0, 0, 0, 1, 2'b00); exp_q.push_back(model("R9 b2b a"));
    @(negedge clk);
    set_ctl(2'd2, 1, 0, 0, 0, 0, 0, 0, 1, 2'b00); exp_q.push_back(model("R9 b2b b"));
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      set_ctl(r[1:0], r[2] | r[3], r[4], r[5], r[6], r[7], r[8], r[9], r[10], r[12:11]);
      req_is_write = r[13];
      good_enc();
      if (r[15:14] == 2'b00) enc_crn = 4'($urandom);
      send("R8 random");
    end
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule